// File: doc/BRIEF.md
# Start-Stop Serial Character Receiver

This block recovers characters from an idle-high asynchronous serial line in which every character is wrapped between a low start element and a high stop element. The line is first passed through a short synchronizer. A falling edge seen while the receiver is idle starts a new bit-timing sequence. Each following element is sampled once, near the middle of its bit-time. The timing is taken from that edge alone, so every character re-times the receiver, however much gap or phase shift lies between characters.

The character format is set at run time: five to eight data bits, an optional parity element with an even or odd rule, and a divisor giving the number of clock cycles per bit. When the stop element has been sampled, the assembled character is presented together with a one-clock valid strobe and two error flags, one for parity and one for framing. A short low glitch on an idle line is discarded. After a framing error that leaves the line low, the receiver stays disarmed until the line has returned high.

Top module: `serial_char_rx`

## Requirements
- R1: While and just after reset, `rx_valid`, `rx_par_err`, `rx_frm_err` are 0 and `rx_data` is 0.
- R2: A 1-to-0 transition of the synchronized line while idle starts a character. Every element is sampled near its centre, timed from that edge only, so characters arriving after any idle gap (including none) are received correctly.
- R3: Data bits are taken least significant bit first into `rx_data[0]` upward. `cfg_len` selects the count (0 = 5, 1 = 6, 2 = 7, 3 = 8 bits), and `rx_data` bits above the configured length read 0.
- R4: With `cfg_par_en` = 1, one parity element follows the data. With `cfg_par_odd` = 0 the count of ones over data plus parity must be even; with 1 it must be odd. A mismatch sets `rx_par_err` with the character.
- R5: With `cfg_par_en` = 0 no parity element is expected, the stop element follows the last data bit directly, and `rx_par_err` stays 0.
- R6: If the element sampled in the stop position is 0, `rx_frm_err` is set with the character; if it is 1, `rx_frm_err` is 0.
- R7: A low pulse on an idle line that has returned high by the start element's midpoint produces no character and no flag.
- R8: `rx_valid` is high for exactly one clock per character. Data and both flags change in that same cycle, and the flags are 0 whenever `rx_valid` is 0.
- R9: After a framing error with the line still low, no new character is started until the line has gone high and then falls again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_div | input | DIV_W | Clock cycles per bit-time (at least 4) |
| cfg_len | input | 2 | Data length code, 0..3 for 5..8 bits |
| cfg_par_en | input | 1 | Parity element present |
| cfg_par_odd | input | 1 | Odd parity rule when 1, even when 0 |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| rx_data | output | 8 | Last received character |
| rx_valid | output | 1 | One-clock strobe for a received character |
| rx_par_err | output | 1 | Parity mismatch, qualified by `rx_valid` |
| rx_frm_err | output | 1 | Stop element sampled low, qualified by `rx_valid` |

## Verification
Several rules are checked by the assertions on every cycle. The valid strobe lasts one cycle and the flags never appear without it. The parity flag stays clear when parity is disabled, data bits above the configured length read zero, and the framing flag matches the synchronized level at the stop sample. The bit timer also ticks only while a character is in progress. Only the bench's scenarios can show the rest: the correct character value for each length, the parity rules, the rejection of glitches, re-timing across varied gaps, and the silence of the receiver while the line stays low after a framing error.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    localparam int CHAR_W = 8;
    localparam int IDX_W  = $clog2(CHAR_W);

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP,
        RX_HOLD
    } rx_state_e;

    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              par_err;
        logic              frm_err;
    } rx_result_t;

    // number of data bits for a length code (0..3 -> 5..8)
    function automatic logic [3:0] char_bits(input logic [1:0] code);
        return 4'd5 + {2'b00, code};
    endfunction

    // 1 when data plus parity element break the selected rule
    function automatic logic parity_fault(input logic [CHAR_W-1:0] d,
                                          input logic pbit,
                                          input logic odd_rule);
        return (^d) ^ pbit ^ odd_rule;
    endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic line_s,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= 1'b1;
                else     chain <= line_in;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], line_in};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b1;
        else     prev <= chain[STAGES-1];
    end

    assign line_s = chain[STAGES-1];
    assign fall   = prev & ~chain[STAGES-1];
endmodule

// File: rtl/rx_bit_timer.sv
module rx_bit_timer #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    input  logic             arm,
    input  logic             run,
    output logic             tick
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] half;

    assign half = {1'b0, div[DIV_W-1:1]};
    assign tick = run && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (arm) begin
            cnt <= half - ONE;
        end else if (run) begin
            if (cnt == '0) cnt <= div - ONE;
            else           cnt <= cnt - ONE;
        end
    end
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import serial_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic       line_s,
    input  logic       fall,
    input  logic       tick,
    output logic       arm,
    output logic       run,
    output rx_result_t result,
    output logic       valid,
    output rx_state_e  state
);
    logic [IDX_W-1:0]  idx;
    logic [CHAR_W-1:0] shreg;
    logic              pbit;
    logic [IDX_W-1:0]  last_idx;

    assign last_idx = IDX_W'(char_bits(cfg_len) - 4'd1);
    assign arm = (state == RX_IDLE) && fall;
    assign run = (state == RX_START) || (state == RX_DATA) ||
                 (state == RX_PAR)   || (state == RX_STOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= RX_IDLE;
            idx    <= '0;
            shreg  <= '0;
            pbit   <= 1'b0;
            result <= '0;
            valid  <= 1'b0;
        end else begin
            valid          <= 1'b0;
            result.par_err <= 1'b0;
            result.frm_err <= 1'b0;
            case (state)
                RX_IDLE: begin
                    if (fall) state <= RX_START;
                end
                RX_START: begin
                    if (tick) begin
                        if (line_s) begin
                            state <= RX_IDLE;
                        end else begin
                            state <= RX_DATA;
                            idx   <= '0;
                            shreg <= '0;
                        end
                    end
                end
                RX_DATA: begin
                    if (tick) begin
                        shreg[idx] <= line_s;
                        if (idx == last_idx) state <= cfg_par_en ? RX_PAR : RX_STOP;
                        else                 idx   <= idx + 1'b1;
                    end
                end
                RX_PAR: begin
                    if (tick) begin
                        pbit  <= line_s;
                        state <= RX_STOP;
                    end
                end
                RX_STOP: begin
                    if (tick) begin
                        valid          <= 1'b1;
                        result.data    <= shreg;
                        result.par_err <= cfg_par_en & parity_fault(shreg, pbit, cfg_par_odd);
                        result.frm_err <= ~line_s;
                        state          <= line_s ? RX_IDLE : RX_HOLD;
                    end
                end
                RX_HOLD: begin
                    if (line_s) state <= RX_IDLE;
                end
                default: state <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/serial_char_rx.sv
module serial_char_rx
    import serial_rx_pkg::*;
#(
    parameter int DIV_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              rx_line,
    output logic [CHAR_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_par_err,
    output logic              rx_frm_err
);
    logic       line_s;
    logic       fall;
    logic       arm;
    logic       run;
    logic       tick;
    rx_result_t result;
    rx_state_e  state;

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .line_in(rx_line),
        .line_s (line_s),
        .fall   (fall)
    );

    rx_bit_timer #(.DIV_W(DIV_W)) u_timer (
        .clk (clk),
        .rst (rst),
        .div (cfg_div),
        .arm (arm),
        .run (run),
        .tick(tick)
    );

    rx_frame_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .cfg_len    (cfg_len),
        .cfg_par_en (cfg_par_en),
        .cfg_par_odd(cfg_par_odd),
        .line_s     (line_s),
        .fall       (fall),
        .tick       (tick),
        .arm        (arm),
        .run        (run),
        .result     (result),
        .valid      (rx_valid),
        .state      (state)
    );

    assign rx_data    = result.data;
    assign rx_par_err = result.par_err;
    assign rx_frm_err = result.frm_err;
endmodule

// File: rtl/serial_char_rx_chk.sv
module serial_char_rx_chk
    import serial_rx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              line_s,
    input logic              tick,
    input rx_state_e         state,
    input logic [1:0]        cfg_len,
    input logic              cfg_par_en,
    input logic [CHAR_W-1:0] rx_data,
    input logic              rx_valid,
    input logic              rx_par_err,
    input logic              rx_frm_err
);
    assert_valid_single_R8: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    assert_flags_need_valid_R8: assert property (@(posedge clk) disable iff (rst)
        (rx_par_err || rx_frm_err) |-> rx_valid);

    assert_no_parity_flag_R5: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !$past(cfg_par_en)) |-> !rx_par_err);

    assert_upper_bits_clear_R3: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> ((rx_data >> char_bits($past(cfg_len))) == '0));

    assert_frame_flag_stop_level_R6: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> (rx_frm_err == !$past(line_s)));

    assert_tick_in_frame_R2: assert property (@(posedge clk) disable iff (rst)
        tick |-> (state != RX_IDLE && state != RX_HOLD));
endmodule

bind serial_char_rx serial_char_rx_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .line_s    (line_s),
    .tick      (tick),
    .state     (state),
    .cfg_len   (cfg_len),
    .cfg_par_en(cfg_par_en),
    .rx_data   (rx_data),
    .rx_valid  (rx_valid),
    .rx_par_err(rx_par_err),
    .rx_frm_err(rx_frm_err)
);

// File: tb/test_serial_char_rx.sv
module test_serial_char_rx;
    localparam int DIV_W = 16;
    localparam int BIT   = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [DIV_W-1:0] cfg_div = DIV_W'(BIT);
    logic [1:0]       cfg_len = 2'd3;
    logic             cfg_par_en = 1'b0;
    logic             cfg_par_odd = 1'b0;
    logic             rx_line = 1'b1;
    logic [7:0]       rx_data;
    logic             rx_valid;
    logic             rx_par_err;
    logic             rx_frm_err;

    int n_cmp = 0;
    int n_bad = 0;
    int got_n = 0;
    logic [7:0] got_d = '0;
    logic got_pe = 1'b0;
    logic got_fe = 1'b0;
    int strobe_faults = 0;
    logic prev_v = 1'b0;

    always #5 clk = ~clk;

    serial_char_rx #(.DIV_W(DIV_W)) i_serial_char_rx (
        .clk(clk), .rst(rst), .cfg_div(cfg_div), .cfg_len(cfg_len),
        .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .rx_line(rx_line),
        .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err)
    );

    // monitor: capture strobes, watch strobe width and flag qualification (R8)
    always @(negedge clk) begin
        if (!rst) begin
            if (rx_valid) begin
                got_n  = got_n + 1;
                got_d  = rx_data;
                got_pe = rx_par_err;
                got_fe = rx_frm_err;
            end
            if (rx_valid && prev_v) strobe_faults = strobe_faults + 1;
            if ((rx_par_err || rx_frm_err) && !rx_valid) strobe_faults = strobe_faults + 1;
            prev_v = rx_valid;
        end
    end

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        rx_line = b;
        repeat (BIT) @(negedge clk);
    endtask

    task automatic drive_frame(input logic [7:0] d, input int nbits, input bit pen,
                               input bit podd, input bit flip_par, input logic stop_lvl);
        logic [7:0] dm;
        logic p;
        dm = d & ((8'd1 << nbits) - 8'd1);
        @(negedge clk);
        cfg_len = 2'(nbits - 5);
        cfg_par_en = pen;
        cfg_par_odd = podd;
        send_bit(1'b0);
        for (int i = 0; i < nbits; i++) send_bit(dm[i]);
        if (pen) begin
            p = (^dm) ^ podd;
            if (flip_par) p = ~p;
            send_bit(p);
        end
        send_bit(stop_lvl);
    endtask

    task automatic receive(input string req, input logic [7:0] d, input int nbits,
                           input bit pen, input bit podd, input bit flip_par,
                           input logic stop_lvl, input logic exp_pe, input logic exp_fe);
        int n0;
        n0 = got_n;
        drive_frame(d, nbits, pen, podd, flip_par, stop_lvl);
        check_eq({req, " count"}, got_n, n0 + 1);
        check_eq({req, " data"}, got_d, d & ((8'd1 << nbits) - 8'd1));
        check_eq({req, " par_err"}, got_pe, exp_pe);
        check_eq({req, " frm_err"}, got_fe, exp_fe);
    endtask

    task automatic t_reset();
        check_eq("R1 valid", rx_valid, 0);
        check_eq("R1 data", rx_data, 0);
        check_eq("R1 flags", {rx_par_err, rx_frm_err}, 0);
    endtask

    task automatic t_basic();
        receive("R2 R3 R5 8N1 A5", 8'hA5, 8, 0, 0, 0, 1'b1, 0, 0);
        receive("R3 8N1 01", 8'h01, 8, 0, 0, 0, 1'b1, 0, 0);
    endtask

    task automatic t_lengths();
        receive("R3 len5", 8'hFF, 5, 0, 0, 0, 1'b1, 0, 0);
        receive("R3 len6", 8'hEA, 6, 0, 0, 0, 1'b1, 0, 0);
        receive("R3 len7", 8'h5B, 7, 0, 0, 0, 1'b1, 0, 0);
    endtask

    task automatic t_parity();
        receive("R4 even ok", 8'h37, 8, 1, 0, 0, 1'b1, 0, 0);
        receive("R4 odd ok", 8'h37, 8, 1, 1, 0, 1'b1, 0, 0);
        receive("R4 even bad", 8'h0C, 7, 1, 0, 1, 1'b1, 1, 0);
        receive("R4 odd bad", 8'h13, 5, 1, 1, 1, 1'b1, 1, 0);
        receive("R5 no parity", 8'h81, 8, 0, 1, 0, 1'b1, 0, 0);
    endtask

    task automatic t_framing();
        int n0;
        receive("R6 stop low", 8'h3C, 8, 0, 0, 0, 1'b0, 0, 1);
        n0 = got_n;
        rx_line = 1'b0;
        repeat (3 * BIT) @(negedge clk);
        check_eq("R9 silent while low", got_n, n0);
        rx_line = 1'b1;
        repeat (2 * BIT) @(negedge clk);
        receive("R9 after recovery", 8'hC3, 8, 1, 1, 0, 1'b1, 0, 0);
        receive("R6 stop low parity", 8'h55, 6, 1, 0, 0, 1'b0, 0, 1);
        rx_line = 1'b1;
        repeat (2 * BIT) @(negedge clk);
    endtask

    task automatic t_noise();
        int n0;
        n0 = got_n;
        rx_line = 1'b0;
        repeat (3) @(negedge clk);
        rx_line = 1'b1;
        repeat (3 * BIT) @(negedge clk);
        check_eq("R7 glitch ignored", got_n, n0);
        receive("R7 after glitch", 8'h96, 8, 0, 0, 0, 1'b1, 0, 0);
    endtask

    task automatic t_resync();
        receive("R2 back to back a", 8'h11, 8, 0, 0, 0, 1'b1, 0, 0);
        receive("R2 back to back b", 8'hEE, 8, 0, 0, 0, 1'b1, 0, 0);
        rx_line = 1'b1;
        repeat (5) @(negedge clk);
        receive("R2 gap 5", 8'h6D, 8, 0, 0, 0, 1'b1, 0, 0);
        repeat (11) @(negedge clk);
        receive("R2 gap 11", 8'h1F, 7, 1, 1, 0, 1'b1, 0, 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        t_reset();
        rst = 1'b0;
        repeat (2 * BIT) @(negedge clk);
        t_reset();
        t_basic();
        t_lengths();
        t_parity();
        t_framing();
        t_noise();
        t_resync();
        check_eq("R8 strobe width and flag qualification", strobe_faults, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule